// File: doc/BRIEF.md
# Interrupt Source Routing Table

This block keeps one routing entry for each interrupt source, addressed by the source's global number. An entry holds the processor to deliver to, a priority, and the logical interrupt number that the target will see in place of the source number. When a source event arrives, the block looks up its entry. An entry that is enabled sends a delivery record (logical number, target, priority) to the queue stage through a valid/ready output. An entry that is masked drops the event at once.

Masking has no separate enable bit. A priority value of 0xFF means the entry is masked. Software programs entries through a register-style port. The port writes the entry selected by `cfg_idx` on `cfg_wr` and always presents a read view of that same entry. Some sources are marked as escalation sources at build time, and a mask request has no effect on their priority. A sync request lets software wait until every event accepted so far has left the block.

Top module: `irq_route_table`

## Requirements
- R1: After reset every entry reads priority 0xFF, target 0xFFFFFFFF and logical number equal to its own index, and `out_valid` is low.
- R2: A write with a priority from 0 to 7 stores the target, priority and logical number. The read view of that index returns all three from the next cycle on.
- R3: An event for an entry whose priority is 0xFF is accepted and discarded. No delivery record is produced for it.
- R4: An event for an enabled entry is accepted when `evt_ready` is high. In the next cycle it appears on `out_valid` with the entry's logical number, target and priority. Those fields stay stable while `out_ready` is low.
- R5: A write with priority 0xFF masks an ordinary entry and still stores its target and logical number. The read view of a masked entry shows the target as 0xFFFFFFFF.
- R6: Sources 62 and 63 (the default escalation set) keep their previous priority when written with 0xFF. Their target and logical number are still updated.
- R7: A write with a priority from 8 to 0xFE leaves the entry unchanged.
- R8: When a write and an event lookup name the same entry in the same cycle, the lookup uses the newly written value.
- R9: `evt_ready` is low while a delivery record is held and `out_ready` is low. No event is lost under backpressure.
- R10: After a one-cycle `sync_req`, `sync_done` pulses once, and only after every event accepted in or before the request cycle has been handed over on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the entry at cfg_idx |
| cfg_idx | input | 6 | Entry index for write and read view |
| cfg_wtgt | input | 32 | Target to write |
| cfg_wprio | input | 8 | Priority to write (0xFF masks) |
| cfg_wlirq | input | 30 | Logical number to write |
| cfg_rtgt | output | 32 | Read view: target (all ones if masked) |
| cfg_rprio | output | 8 | Read view: priority |
| cfg_rlirq | output | 30 | Read view: logical number |
| evt_valid | input | 1 | Source event present |
| evt_src | input | 6 | Global source number of the event |
| evt_ready | output | 1 | Event accepted this cycle when high with evt_valid |
| out_valid | output | 1 | Delivery record present |
| out_ready | input | 1 | Queue stage takes the record |
| out_lirq | output | 30 | Logical number delivered |
| out_tgt | output | 32 | Target processor |
| out_prio | output | 8 | Delivery priority |
| sync_req | input | 1 | Request a drain notification |
| sync_done | output | 1 | One-cycle drain notification |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a configuration write and an event lookup. The bench drives `cfg_wr` and `evt_valid` to the same index on one edge, once to unmask an entry and once to mask it. It then requires a delivery with the new fields in the first case and no delivery in the second. The second pair is a sync request and a held delivery record under backpressure. The bench stalls the output, raises `sync_req`, and checks that no `sync_done` appears until the stalled record is handed over. It also checks that exactly one pulse follows.

// File: rtl/irt_pkg.sv
package irt_pkg;

    localparam int TGT_W  = 32;
    localparam int PRIO_W = 8;
    localparam int LIRQ_W = 30;
    localparam int NPRIO  = 8;
    localparam logic [PRIO_W-1:0] MASK_PRIO = '1;

    typedef struct packed {
        logic [TGT_W-1:0]  tgt;
        logic [PRIO_W-1:0] prio;
        logic [LIRQ_W-1:0] lirq;
    } irt_entry_t;

    // New entry value after a configuration write
    function automatic irt_entry_t irt_merge(
        input irt_entry_t        old,
        input logic [TGT_W-1:0]  wtgt,
        input logic [PRIO_W-1:0] wprio,
        input logic [LIRQ_W-1:0] wlirq,
        input logic              esc
    );
        irt_entry_t nv;
        nv = old;
        if (wprio == MASK_PRIO) begin
            nv.tgt  = wtgt;
            nv.lirq = wlirq;
            nv.prio = esc ? old.prio : MASK_PRIO;
        end else if (int'(wprio) < NPRIO) begin
            nv.tgt  = wtgt;
            nv.lirq = wlirq;
            nv.prio = wprio;
        end
        return nv;
    endfunction

endpackage

// File: rtl/irt_table.sv
module irt_table
    import irt_pkg::*;
#(
    parameter int                  NUM_SRC = 64,
    parameter int                  IDX_W   = $clog2(NUM_SRC),
    parameter logic [NUM_SRC-1:0]  ESC_SRC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [TGT_W-1:0]  cfg_wtgt,
    input  logic [PRIO_W-1:0] cfg_wprio,
    input  logic [LIRQ_W-1:0] cfg_wlirq,
    output irt_entry_t        rd_ent,
    input  logic [IDX_W-1:0]  lk_src,
    output irt_entry_t        lk_ent
);

    typedef struct packed {
        irt_entry_t [NUM_SRC-1:0] ent;
    } tbl_state_t;

    tbl_state_t tbl_d, tbl_q;
    irt_entry_t wr_new;
    irt_entry_t cur_rd;

    always_comb begin
        tbl_d  = tbl_q;
        wr_new = irt_merge(tbl_q.ent[cfg_idx], cfg_wtgt, cfg_wprio, cfg_wlirq,
                           ESC_SRC[cfg_idx]);
        if (cfg_wr) begin
            tbl_d.ent[cfg_idx] = wr_new;
        end
        // write before lookup on the same entry
        if (cfg_wr && (cfg_idx == lk_src)) begin
            lk_ent = wr_new;
        end else begin
            lk_ent = tbl_q.ent[lk_src];
        end
        cur_rd = tbl_q.ent[cfg_idx];
        rd_ent = cur_rd;
        if (cur_rd.prio == MASK_PRIO) begin
            rd_ent.tgt = '1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                tbl_q.ent[i].tgt  <= '1;
                tbl_q.ent[i].prio <= MASK_PRIO;
                tbl_q.ent[i].lirq <= LIRQ_W'(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    // R7: out-of-range priority leaves the entry as it was
    p_bad_prio_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wprio != MASK_PRIO && int'(cfg_wprio) >= NPRIO)
        |=> tbl_q.ent[$past(cfg_idx)] == $past(tbl_q.ent[cfg_idx]));

    // R6: escalation entries keep their priority on a mask request
    p_esc_no_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && ESC_SRC[cfg_idx] && cfg_wprio == MASK_PRIO)
        |=> tbl_q.ent[$past(cfg_idx)].prio == $past(tbl_q.ent[cfg_idx].prio));

endmodule

// File: rtl/irt_egress.sv
module irt_egress
    import irt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  irt_entry_t load_ent,
    output logic       can_take,
    output logic       out_valid,
    input  logic       out_ready,
    output irt_entry_t out_ent,
    input  logic       sync_req,
    output logic       sync_done
);

    typedef struct packed {
        logic       valid;
        irt_entry_t item;
        logic       pend;
        logic       done;
    } eg_state_t;

    eg_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        can_take = !st_q.valid || out_ready;
        if (st_q.valid && out_ready) begin
            st_d.valid = 1'b0;
        end
        if (load) begin
            st_d.valid = 1'b1;
            st_d.item  = load_ent;
        end
        // drained once nothing older than the request is held
        st_d.done = st_q.pend && (!st_q.valid || out_ready);
        st_d.pend = sync_req || (st_q.pend && !st_d.done);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.item  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_ent   = st_q.item;
    assign sync_done = st_q.done;

    // R4: a held record does not change under backpressure
    p_hold_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_ent)));

    // R9: no new event is taken while the record is stalled
    p_stall_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !can_take);

endmodule

// File: rtl/irq_route_table.sv
module irq_route_table
    import irt_pkg::*;
#(
    parameter int                 NUM_SRC = 64,
    parameter logic [NUM_SRC-1:0] ESC_SRC = {2'b11, {(NUM_SRC-2){1'b0}}},
    localparam int                IDX_W   = $clog2(NUM_SRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [TGT_W-1:0]  cfg_wtgt,
    input  logic [PRIO_W-1:0] cfg_wprio,
    input  logic [LIRQ_W-1:0] cfg_wlirq,
    output logic [TGT_W-1:0]  cfg_rtgt,
    output logic [PRIO_W-1:0] cfg_rprio,
    output logic [LIRQ_W-1:0] cfg_rlirq,
    input  logic              evt_valid,
    input  logic [IDX_W-1:0]  evt_src,
    output logic              evt_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [LIRQ_W-1:0] out_lirq,
    output logic [TGT_W-1:0]  out_tgt,
    output logic [PRIO_W-1:0] out_prio,
    input  logic              sync_req,
    output logic              sync_done
);

    irt_entry_t rd_ent, lk_ent, out_ent;
    logic       can_take, load;

    irt_table #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .ESC_SRC(ESC_SRC)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (cfg_wr),
        .cfg_idx   (cfg_idx),
        .cfg_wtgt  (cfg_wtgt),
        .cfg_wprio (cfg_wprio),
        .cfg_wlirq (cfg_wlirq),
        .rd_ent    (rd_ent),
        .lk_src    (evt_src),
        .lk_ent    (lk_ent)
    );

    // accepted events with a masked entry are simply not loaded
    assign load = evt_valid && can_take && (lk_ent.prio != MASK_PRIO);

    irt_egress u_eg (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_ent  (lk_ent),
        .can_take  (can_take),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_ent   (out_ent),
        .sync_req  (sync_req),
        .sync_done (sync_done)
    );

    assign evt_ready = can_take;
    assign cfg_rtgt  = rd_ent.tgt;
    assign cfg_rprio = rd_ent.prio;
    assign cfg_rlirq = rd_ent.lirq;
    assign out_lirq  = out_ent.lirq;
    assign out_tgt   = out_ent.tgt;
    assign out_prio  = out_ent.prio;

    // R3: a masked priority never reaches the queue stage
    p_no_masked_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_prio) < NPRIO));

endmodule

// File: tb/sim_irq_route_table.sv
module sim_irq_route_table;

    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic [31:0] cfg_wtgt = '0;
    logic [7:0]  cfg_wprio = '0;
    logic [29:0] cfg_wlirq = '0;
    logic [31:0] cfg_rtgt;
    logic [7:0]  cfg_rprio;
    logic [29:0] cfg_rlirq;
    logic        evt_valid = 1'b0;
    logic [5:0]  evt_src = '0;
    logic        evt_ready;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [29:0] out_lirq;
    logic [31:0] out_tgt;
    logic [7:0]  out_prio;
    logic        sync_req = 1'b0;
    logic        sync_done;

    irq_route_table u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int done_cnt = 0;
    logic [69:0] exp_q[$];

    logic [31:0] m_tgt [NSRC];
    logic [7:0]  m_prio[NSRC];
    logic [29:0] m_lirq[NSRC];

    task automatic chk(input bit ok, input string tag, input string msg);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: %s", tag, msg);
        end
    endtask

    function automatic void m_write(int i, logic [31:0] t, logic [7:0] p, logic [29:0] l);
        if (p == 8'hFF) begin
            m_tgt[i] = t; m_lirq[i] = l;
            if (i < 62) m_prio[i] = 8'hFF;
        end else if (p < 8) begin
            m_tgt[i] = t; m_lirq[i] = l; m_prio[i] = p;
        end
    endfunction

    function automatic void m_event(int i);
        if (m_prio[i] != 8'hFF) exp_q.push_back({m_tgt[i], m_prio[i], m_lirq[i]});
    endfunction

    // monitor / scoreboard
    always begin
        @(negedge clk);
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", $sformatf("unexpected record act lirq=%h exp none", out_lirq));
            end else begin
                logic [69:0] e;
                e = exp_q.pop_front();
                chk({out_tgt, out_prio, out_lirq} == e, "R4",
                    $sformatf("act %h exp %h", {out_tgt, out_prio, out_lirq}, e));
            end
        end
        if (rst_n && sync_done) done_cnt++;
    end

    task automatic wr(int i, logic [31:0] t, logic [7:0] p, logic [29:0] l);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'(i); cfg_wtgt = t; cfg_wprio = p; cfg_wlirq = l;
        m_write(i, t, p, l);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_chk(int i, string tag);
        logic [31:0] et;
        @(negedge clk);
        cfg_idx = 6'(i);
        #1;
        et = (m_prio[i] == 8'hFF) ? 32'hFFFF_FFFF : m_tgt[i];
        chk(cfg_rprio == m_prio[i] && cfg_rtgt == et && cfg_rlirq == m_lirq[i], tag,
            $sformatf("idx %0d act %h/%h/%h exp %h/%h/%h", i, cfg_rtgt, cfg_rprio, cfg_rlirq,
                      et, m_prio[i], m_lirq[i]));
    endtask

    task automatic send(int i);
        @(negedge clk);
        evt_valid = 1'b1; evt_src = 6'(i);
        #1;
        while (!evt_ready) begin
            @(negedge clk);
            #1;
        end
        m_event(i);
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    // write and event to the same index on one edge (R8)
    task automatic wr_send(int i, logic [31:0] t, logic [7:0] p, logic [29:0] l);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 6'(i); cfg_wtgt = t; cfg_wprio = p; cfg_wlirq = l;
        evt_valid = 1'b1; evt_src = 6'(i);
        #1;
        chk(evt_ready == 1'b1, "R8", $sformatf("evt_ready act %b exp 1", evt_ready));
        m_write(i, t, p, l);
        m_event(i);
        @(negedge clk);
        cfg_wr = 1'b0; evt_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_up;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog", "run hung act running exp finished");
        finish_up();
    end

    initial begin
        logic [69:0] held;
        int d0;
        for (int i = 0; i < NSRC; i++) begin
            m_tgt[i] = 32'hFFFF_FFFF; m_prio[i] = 8'hFF; m_lirq[i] = 30'(i);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk(out_valid == 1'b0, "R1", $sformatf("out_valid act %b exp 0", out_valid));
        for (int i = 0; i < NSRC; i++) rd_chk(i, "R1");

        // R3 masked after reset: dropped
        send(5);
        send(40);
        idle(3);
        chk(exp_q.size() == 0 && out_valid == 1'b0, "R3",
            $sformatf("out_valid act %b exp 0", out_valid));

        // R2 / R4 basic routing, several patterns
        wr(5, 32'h1234_5678, 8'd3, 30'h2AAA_AAAA);
        rd_chk(5, "R2");
        wr(6, 32'h0000_0001, 8'd0, 30'h0000_0100);
        wr(7, 32'hDEAD_0007, 8'd7, 30'h3FFF_FFFF);
        rd_chk(6, "R2");
        rd_chk(7, "R2");
        send(5);
        send(6);
        send(7);
        send(5);
        idle(3);
        chk(exp_q.size() == 0, "R4", $sformatf("pending act %0d exp 0", exp_q.size()));

        // R5 mask write
        wr(5, 32'h5555_0000, 8'hFF, 30'h0000_0ABC);
        rd_chk(5, "R5");
        send(5);
        idle(3);
        chk(exp_q.size() == 0 && out_valid == 1'b0, "R5",
            $sformatf("out_valid act %b exp 0", out_valid));

        // R7 out-of-range priorities
        wr(6, 32'h7777_7777, 8'd8, 30'h1);
        rd_chk(6, "R7");
        wr(6, 32'h7777_7777, 8'hFE, 30'h2);
        rd_chk(6, "R7");

        // R6 escalation sources ignore masking
        wr(63, 32'h0000_0063, 8'd2, 30'h0000_3003);
        wr(63, 32'h0000_1063, 8'hFF, 30'h0000_4004);
        rd_chk(63, "R6");
        send(63);
        wr(62, 32'h0000_0062, 8'hFF, 30'h0000_0062);
        rd_chk(62, "R6");
        idle(3);
        chk(exp_q.size() == 0, "R6", $sformatf("pending act %0d exp 0", exp_q.size()));

        // R8 same-cycle write and lookup
        wr_send(10, 32'h0A0A_0A0A, 8'd4, 30'h0000_0A10);
        idle(2);
        wr_send(10, 32'h0B0B_0B0B, 8'hFF, 30'h0000_0B10);
        idle(3);
        chk(exp_q.size() == 0 && out_valid == 1'b0, "R8",
            $sformatf("out_valid act %b exp 0", out_valid));

        // R9 / R4 / R10 under backpressure
        wr(20, 32'h2020_2020, 8'd1, 30'h0000_2020);
        out_ready = 1'b0;
        send(20);
        #1;
        chk(out_valid == 1'b1, "R9", $sformatf("out_valid act %b exp 1", out_valid));
        held = {out_tgt, out_prio, out_lirq};
        d0 = done_cnt;
        @(negedge clk);
        evt_valid = 1'b1; evt_src = 6'd20; sync_req = 1'b1;
        #1;
        chk(evt_ready == 1'b0, "R9", $sformatf("evt_ready act %b exp 0", evt_ready));
        @(negedge clk);
        sync_req = 1'b0;
        idle(2);
        #1;
        chk({out_tgt, out_prio, out_lirq} == held, "R4",
            $sformatf("held act %h exp %h", {out_tgt, out_prio, out_lirq}, held));
        chk(done_cnt == d0, "R10", $sformatf("done pulses act %0d exp %0d", done_cnt, d0));
        chk(evt_ready == 1'b0, "R9", $sformatf("evt_ready act %b exp 0", evt_ready));
        @(negedge clk);
        out_ready = 1'b1;
        m_event(20);
        #1;
        chk(evt_ready == 1'b1, "R9", $sformatf("evt_ready act %b exp 1", evt_ready));
        @(negedge clk);
        evt_valid = 1'b0;
        idle(4);
        chk(done_cnt == d0 + 1, "R10", $sformatf("done pulses act %0d exp %0d", done_cnt, d0 + 1));
        chk(exp_q.size() == 0, "R9", $sformatf("pending act %0d exp 0", exp_q.size()));

        // R10 with nothing held
        d0 = done_cnt;
        @(negedge clk);
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        idle(3);
        chk(done_cnt == d0 + 1, "R10", $sformatf("done pulses act %0d exp %0d", done_cnt, d0 + 1));

        idle(2);
        finish_up();
    end

endmodule